// File: doc/BRIEF.md
# PWM Pulse Width Capture

This block measures how long a servo-style PWM input stays high and reports that time as a whole number of programmable time units. The input has no timing relation to the system clock. It passes through a flop synchronizer and then a three-sample majority vote before any edge detection. A tick counter, whose terminal count comes from the `uiTicks` input, divides the clock into units. A unit counter advances once per completed unit while the filtered input is high.

On the falling edge the block rounds the count to the nearest unit, latches it on `widthUi` and pulses `done` for one cycle. Only the high time matters. The block expects no frame rate or pulse period, so consecutive pulses can be separated by gaps of any length. A soft reset clears the captured result and drops any pulse in flight. The block has no bus interface: the width, the tick setting and the completion pulse connect directly to whatever register file the chip uses.

Top module: `pwm_width_capture`

## Requirements
- R1: After `rstN` is released and before any pulse completes, `widthUi` reads 0 and `done` is low.
- R2: While `uiTicks` is 0, capture is disabled and no pulse produces `done`.
- R3: `pwmIn` passes through a two-flop synchronizer and a majority vote over three consecutive samples. An isolated one-cycle high on `pwmIn` produces no measurement. A one-cycle low inside a high pulse does not split that pulse.
- R4: One unit lasts `uiTicks`+1 clock cycles. A high time of H cycles yields floor(H/(`uiTicks`+1)) whole units before rounding.
- R5: If the leftover cycle count r within the last partial unit satisfies 2·r ≥ `uiTicks`+1, the reported width is one unit more than the whole-unit count.
- R6: `done` is high for exactly one cycle per completed pulse. It rises on the fifth clock edge after `pwmIn` falls. `widthUi` takes the new value on that same edge and holds it until the next completion or soft reset.
- R7: The reported width saturates at 4095 and does not wrap.
- R8: A falling edge that was not preceded by a rising edge seen while capture was enabled produces no measurement.
- R9: A change of `uiTicks` while a pulse is high abandons that pulse, and no `done` follows it.
- R10: A one-cycle `softRst` sets `widthUi` to 0 on the next edge and abandons any pulse in flight.
- R11: Pulses separated by low gaps of any length are each measured on their own, with no assumption about frame period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 1 | Asynchronous PWM input |
| uiTicks | input | 12 | Clock cycles per unit minus one; 0 disables capture |
| softRst | input | 1 | Synchronous clear of result and capture state |
| widthUi | output | 12 | Latched width of the last pulse in units |
| done | output | 1 | One-cycle pulse when a new width is latched |

## Verification
The filter path delays both edges of `pwmIn` equally, by four clock edges. A latching edge follows, so `done` and the new `widthUi` are due on the fifth rising edge after the input falls. The bench drives inputs on falling edges and counts falling edges from the release of `pwmIn`. It requires `done` on exactly the fifth one and reads `widthUi` there. Cases where no measurement is expected watch `done` for twenty cycles after the input falls, then confirm that `widthUi` has not moved. The effect of a soft reset is read one falling edge after it is applied.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;
  typedef struct packed {
    logic start;   // first high cycle of an armed pulse
    logic count;   // further high cycle of an armed pulse
    logic finish;  // falling edge of an armed pulse
    logic clear;   // abandon counters
    logic wipe;    // clear latched result
  } capStrobe_t;
endpackage

// File: rtl/pwm_cap_ctrl.sv
module pwm_cap_ctrl
  import pwm_cap_pkg::*;
#(
  parameter int SYNC_W = 2,
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwmIn,
  input  logic [TICK_W-1:0] uiTicks,
  input  logic              softRst,
  output capStrobe_t        strobe
);
  logic [SYNC_W-1:0] syncQ;
  logic [1:0]        hist;
  logic              sample, filt, filtPrev, armed;
  logic [TICK_W-1:0] ticksPrev;
  logic              enable, changed, abandon, rise, fall;

  assign sample = syncQ[SYNC_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      hist     <= '0;
      filt     <= 1'b0;
      filtPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_W-2:0], pwmIn};
      hist     <= {hist[0], sample};
      filt     <= (sample & hist[0]) | (sample & hist[1]) | (hist[0] & hist[1]);
      filtPrev <= filt;
    end
  end

  assign enable  = (uiTicks != '0);
  assign changed = (uiTicks != ticksPrev);
  assign abandon = softRst | changed;
  assign rise    = filt & ~filtPrev;
  assign fall    = ~filt & filtPrev;

  always_comb begin
    strobe.start  = rise & enable & ~abandon;
    strobe.count  = armed & filt & ~abandon;
    strobe.finish = fall & armed & ~abandon;
    strobe.clear  = abandon;
    strobe.wipe   = softRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      ticksPrev <= '0;
    end else begin
      ticksPrev <= uiTicks;
      if (abandon)           armed <= 1'b0;
      else if (strobe.start) armed <= 1'b1;
      else if (fall)         armed <= 1'b0;
    end
  end

  // R11: a new pulse can only start once the previous one has ended
  p_start_when_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> !armed);
endmodule

// File: rtl/pwm_cap_dp.sv
module pwm_cap_dp
  import pwm_cap_pkg::*;
#(
  parameter int TICK_W  = 12,
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TICK_W-1:0]  uiTicks,
  input  capStrobe_t         strobe,
  output logic [WIDTH_W-1:0] widthUi,
  output logic               done
);
  localparam logic [WIDTH_W-1:0] UI_MAX = '1;
  localparam int DBL_W = TICK_W + 2;

  logic [TICK_W-1:0]  tickCnt, baseTick, nextTick;
  logic [WIDTH_W-1:0] uiCnt, baseUi, nextUi, rounded;
  logic [DBL_W-1:0]   dblTick, uiLen;
  logic               wrap, halfUp;

  always_comb begin
    baseTick = strobe.start ? '0 : tickCnt;
    baseUi   = strobe.start ? '0 : uiCnt;
    wrap     = (baseTick == uiTicks);
    nextTick = wrap ? '0 : baseTick + 1'b1;
    nextUi   = (wrap && baseUi != UI_MAX) ? baseUi + 1'b1 : baseUi;
    dblTick  = {1'b0, tickCnt, 1'b0};
    uiLen    = {2'b00, uiTicks} + 1'b1;
    halfUp   = (dblTick >= uiLen);
    rounded  = (halfUp && uiCnt != UI_MAX) ? uiCnt + 1'b1 : uiCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      uiCnt   <= '0;
      widthUi <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.wipe) widthUi <= '0;
      if (strobe.clear) begin
        tickCnt <= '0;
        uiCnt   <= '0;
      end else if (strobe.start || strobe.count) begin
        tickCnt <= nextTick;
        uiCnt   <= nextUi;
      end
      if (strobe.finish) begin
        widthUi <= rounded;
        done    <= 1'b1;
      end
    end
  end

  // R2: no completion follows a cycle with capture disabled
  p_disabled_no_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (uiTicks == '0) |=> !done);
  // R6: completion is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: result holds between completions and soft resets
  p_width_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !$past(strobe.wipe)) |-> $stable(widthUi));
  // R7: unit counter never wraps past its maximum
  p_ui_saturate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (uiCnt == UI_MAX && strobe.count && !strobe.clear) |=> (uiCnt == UI_MAX));
endmodule

// File: rtl/pwm_width_capture.sv
module pwm_width_capture
  import pwm_cap_pkg::*;
#(
  parameter int SYNC_W  = 2,
  parameter int TICK_W  = 12,
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmIn,
  input  logic [TICK_W-1:0]  uiTicks,
  input  logic               softRst,
  output logic [WIDTH_W-1:0] widthUi,
  output logic               done
);
  capStrobe_t strobe;

  pwm_cap_ctrl #(.SYNC_W(SYNC_W), .TICK_W(TICK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .uiTicks(uiTicks),
    .softRst(softRst), .strobe(strobe)
  );

  pwm_cap_dp #(.TICK_W(TICK_W), .WIDTH_W(WIDTH_W)) uDp (
    .clk(clk), .rstN(rstN), .uiTicks(uiTicks), .strobe(strobe),
    .widthUi(widthUi), .done(done)
  );
endmodule

// File: tb/pwm_width_capture_test.sv
module pwm_width_capture_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwmIn = 1'b0;
  logic [11:0] uiTicks = '0;
  logic        softRst = 1'b0;
  logic [11:0] widthUi;
  logic        done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_width_capture uut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .uiTicks(uiTicks),
    .softRst(softRst), .widthUi(widthUi), .done(done)
  );

  function automatic int expWidth(int t, int h);
    int n = t + 1;
    int q = h / n;
    int r = h % n;
    int e = q + ((2 * r >= n) ? 1 : 0);
    return (e > 4095) ? 4095 : e;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setTicks(int t);
    @(negedge clk);
    uiTicks = 12'(t);
    repeat (3) @(negedge clk);
  endtask

  // drive high for h cycles, then look for done on the fifth falling edge
  task automatic pulse(string req, int h, int gap, int exp);
    int lat;
    int prev;
    prev = widthUi;
    @(negedge clk);
    pwmIn = 1'b1;
    repeat (h) @(negedge clk);
    pwmIn = 1'b0;
    lat = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (done && lat == 0) begin
        lat = k;
        if (exp >= 0) check({req, " width"}, widthUi, exp);
      end
    end
    if (exp >= 0) check({req, " latency"}, lat, 5);
    else begin
      check({req, " no done"}, lat, 0);
      check({req, " width kept"}, widthUi, prev);
    end
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 width", widthUi, 0);
    check("R1 done", done, 0);

    // R2: disabled capture
    pulse("R2", 10, 2, -1);

    // R4 R5 R11: sweep unit lengths and high times with varying gaps
    for (int t = 1; t <= 5; t++) begin
      setTicks(t);
      for (int h = 2; h <= 24; h++)
        pulse("R4_R5_R11 sweep", h, (h * 7) % 5, expWidth(t, h));
    end

    // R3: isolated one-cycle glitch is filtered
    setTicks(1);
    pulse("R3 glitch", 1, 3, -1);
    // R3: one-cycle dip inside a pulse does not split it
    @(negedge clk);
    pwmIn = 1'b1;
    repeat (10) @(negedge clk);
    pwmIn = 1'b0;
    @(negedge clk);
    pwmIn = 1'b1;
    repeat (10) @(negedge clk);
    pwmIn = 1'b0;
    begin
      int seen = 0;
      int w = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (done) begin seen++; w = widthUi; end
      end
      check("R3 dip count", seen, 1);
      check("R3 dip width", w, expWidth(1, 21));
    end

    // R7: saturation
    pulse("R7 saturate", 9000, 2, 4095);

    // R4: 1 ms at 50 MHz with 49 ticks
    setTicks(49);
    pulse("R4 one ms", 50000, 2, 1000);
    pulse("R5 round down", 74, 2, 1);
    pulse("R5 round up", 75, 2, 2);

    // R8: fall without armed rise
    setTicks(0);
    @(negedge clk);
    pwmIn = 1'b1;
    repeat (10) @(negedge clk);
    uiTicks = 12'd3;
    repeat (10) @(negedge clk);
    pwmIn = 1'b0;
    begin
      int seen = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check("R8 no done", seen, 0);
      check("R8 width kept", widthUi, 2);
    end

    // R9: tick change mid-pulse abandons
    setTicks(3);
    @(negedge clk);
    pwmIn = 1'b1;
    repeat (6) @(negedge clk);
    uiTicks = 12'd4;
    repeat (6) @(negedge clk);
    pwmIn = 1'b0;
    begin
      int seen = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check("R9 no done", seen, 0);
      check("R9 width kept", widthUi, 2);
    end
    pulse("R9 recover", 17, 2, expWidth(4, 17));

    // R10: soft reset clears result
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    check("R10 cleared", widthUi, 0);
    // R10: soft reset abandons a pulse in flight
    @(negedge clk);
    pwmIn = 1'b1;
    repeat (8) @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    repeat (8) @(negedge clk);
    pwmIn = 1'b0;
    begin
      int seen = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check("R10 no done", seen, 0);
    end
    pulse("R10 recover", 23, 2, expWidth(4, 23));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule